// File: doc/BRIEF.md
# UART Event Status Register

This block holds the event flags a UART reports to its host for interrupt service. It combines three kinds of bit in one 8-bit read-only view:

- **Latched flags.** These catch short event pulses and hold them until the host reads the register.
- **A live flag.** This bit mirrors the transmitter-empty level as it is.
- **A mode-gated flag.** This bit is forced to zero while a select input disables modem-status reporting.

The host reads through a small port made of an address, a read strobe and a write strobe. The view appears on the read data whenever the address matches the register's location. A read strobe at that address clears the latched flags on the following clock edge. Unused and reserved bit positions always read zero.

Top module: `uart_evt_reg`

## Requirements
- R1: While rst_ni is low, and after its release, both latched flags (bit 4 and bit 3) read 0.
- R2: A one-cycle high on dma_tc_i sets bit 4 at the next clock edge. Bit 4 then stays 1 until it is cleared by a read.
- R3: A clearing read is rd_i high, wr_i low and addr_i equal to EVT_ADDR, sampled at a clock edge. It clears bit 4 and bit 3 at that edge.
- R4: If dma_tc_i or ms_chg_i is high in the same cycle as a clearing read, the matching bit is 1 after the edge, so the event is not lost.
- R5: Bit 5 equals txemp_i in the same cycle, with no latching.
- R6: While ms_sel_i is 0, a one-cycle high on ms_chg_i sets bit 3 at the next edge. Bit 3 then holds until it is cleared by a read.
- R7: While ms_sel_i is 1, bit 3 reads 0 and ms_chg_i pulses are not recorded. A flag latched before the select rose is discarded at the first edge with the select high.
- R8: Bits 7, 6, 2, 1 and 0 always read 0.
- R9: None of the following alters the latched flags: a strobe with wr_i high, a read at another address, or a cycle with no strobe. rdata_o is all zeros whenever addr_i differs from EVT_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Host register address |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe, never clears |
| dma_tc_i | input | 1 | DMA terminal-count pulse |
| txemp_i | input | 1 | Transmitter-empty level |
| ms_chg_i | input | 1 | Modem-status change pulse |
| ms_sel_i | input | 1 | 1 masks modem-status events |
| rdata_o | output | 8 | Read data, event view when addressed |

## Verification
The bench builds the block with its defaults: a 3-bit address and the register at address 5. The 3-bit address space lets random addresses fall on the matching location about one cycle in eight. This makes clearing reads and off-address reads both frequent. It also keeps the probability high that pulses collide with clearing reads and with select changes. Directed sequences cover the remaining cases: a pulse arriving during a clear, a write strobe at the register's address, and a flag latched before the select rises.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
  localparam int DATA_W  = 8;
  localparam int MS_BIT  = 3;
  localparam int DMA_BIT = 4;
  localparam int TXE_BIT = 5;
  localparam int N_STICKY = 2;
  // sticky vector order
  localparam int ST_DMA = 0;
  localparam int ST_MS  = 1;
endpackage

// File: rtl/evt_sticky.sv
module evt_sticky #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= set_i[g] | (q & ~clr_i[g]); // set wins over clear
    end
    assign q_o[g] = q;
  end
endmodule

// File: rtl/evt_rd_port.sv
module evt_rd_port #(
  parameter int          ADDR_W   = 3,
  parameter int          DATA_W   = 8,
  parameter logic [ADDR_W-1:0] EVT_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] view_i,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic sel;
  assign sel     = (addr_i == EVT_ADDR);
  assign clr_o   = sel & rd_i & ~wr_i;
  assign rdata_o = sel ? view_i : '0;
endmodule

// File: rtl/uart_evt_reg.sv
module uart_evt_reg
  import uart_evt_pkg::*;
#(
  parameter int          ADDR_W   = 3,
  parameter logic [ADDR_W-1:0] EVT_ADDR = 3'd5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              dma_tc_i,
  input  logic              txemp_i,
  input  logic              ms_chg_i,
  input  logic              ms_sel_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic                rd_hit;
  logic [N_STICKY-1:0] st_set, st_clr, st_q;
  logic [DATA_W-1:0]   evt_view;

  always_comb begin
    st_set         = '0;
    st_clr         = '0;
    st_set[ST_DMA] = dma_tc_i;
    st_clr[ST_DMA] = rd_hit;
    st_set[ST_MS]  = ms_chg_i & ~ms_sel_i;
    st_clr[ST_MS]  = rd_hit | ms_sel_i; // masked mode drops stale flag
  end

  evt_sticky #(.W(N_STICKY)) u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (st_set),
    .clr_i  (st_clr),
    .q_o    (st_q)
  );

  always_comb begin
    evt_view          = '0;
    evt_view[DMA_BIT] = st_q[ST_DMA];
    evt_view[MS_BIT]  = st_q[ST_MS] & ~ms_sel_i;
    evt_view[TXE_BIT] = txemp_i;
  end

  evt_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EVT_ADDR(EVT_ADDR)) u_rd (
    .addr_i  (addr_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .view_i  (evt_view),
    .clr_o   (rd_hit),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/uart_evt_chk.sv
module uart_evt_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_hit,
  input logic              wr_i,
  input logic              dma_tc_i,
  input logic              ms_chg_i,
  input logic              ms_sel_i,
  input logic              txemp_i,
  input logic [DATA_W-1:0] evt_view
);
  // R2
  dma_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_tc_i |=> evt_view[4]);
  // R3
  dma_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && !dma_tc_i) |=> !evt_view[4]);
  // R9
  dma_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_hit && evt_view[4]) |=> evt_view[4]);
  // R6
  ms_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ms_chg_i && !ms_sel_i) |=> (evt_view[3] || ms_sel_i));
  // R7
  ms_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_sel_i |-> !evt_view[3]);
  // R5
  txe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_view[5] == txemp_i);
  // R8
  rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_view[7:6] == 2'b00) && (evt_view[2:0] == 3'b000));
endmodule

bind uart_evt_reg uart_evt_chk #(.DATA_W(8)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_hit   (rd_hit),
  .wr_i     (wr_i),
  .dma_tc_i (dma_tc_i),
  .ms_chg_i (ms_chg_i),
  .ms_sel_i (ms_sel_i),
  .txemp_i  (txemp_i),
  .evt_view (evt_view)
);

// File: tb/uart_evt_reg_tb.sv
module uart_evt_reg_tb;
  localparam logic [2:0] A = 3'd5;

  logic       clk_i = 0, rst_ni = 0;
  logic [2:0] addr_i = 0;
  logic       rd_i = 0, wr_i = 0, dma_tc_i = 0, txemp_i = 0, ms_chg_i = 0, ms_sel_i = 0;
  logic [7:0] rdata_o;

  int n_run = 0, n_fail = 0;
  logic m_dma = 0, m_ms = 0;
  bit   done = 0;

  always #5 clk_i = ~clk_i;

  uart_evt_reg u_dut (.*);

  function automatic logic [7:0] exp_rd(logic [2:0] a, logic dma, logic ms, logic sel, logic txe);
    logic [7:0] v;
    v = {2'b00, txe, dma, ms & ~sel, 3'b000};
    return (a == A) ? v : 8'h00;
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // advance model through one edge using current inputs
  task automatic model_edge();
    logic clr;
    clr   = (addr_i == A) && rd_i && !wr_i;
    m_dma = dma_tc_i | (m_dma & ~clr);
    m_ms  = ms_sel_i ? 1'b0 : (ms_chg_i | (m_ms & ~clr));
  endtask

  task automatic step(logic [2:0] a, logic rd, logic wr, logic dma, logic txe, logic ms, logic sel);
    @(negedge clk_i);
    model_edge();
    addr_i = a; rd_i = rd; wr_i = wr; dma_tc_i = dma; txemp_i = txe; ms_chg_i = ms; ms_sel_i = sel;
    #1;
  endtask

  task automatic look(string req);
    chk(req, rdata_o, exp_rd(addr_i, m_dma, m_ms, ms_sel_i, txemp_i));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    addr_i = A;
    repeat (3) @(negedge clk_i);
    #1 chk("R1 reset view", rdata_o, 8'h00);
    rst_ni = 1;
    step(A, 0, 0, 0, 0, 0, 0); chk("R1 after release", rdata_o, 8'h00);

    // R2 set and hold
    step(A, 0, 0, 1, 0, 0, 0);
    step(A, 0, 0, 0, 0, 0, 0); chk("R2 dma set", rdata_o, 8'h10);
    step(A, 0, 0, 0, 0, 0, 0); chk("R2 dma hold", rdata_o, 8'h10);
    // R9 write at address does not clear
    step(A, 1, 1, 0, 0, 0, 0);
    step(A, 0, 0, 0, 0, 0, 0); chk("R9 write no clear", rdata_o, 8'h10);
    // R9 read elsewhere does not clear, reads zero
    step(3'd2, 1, 0, 0, 1, 0, 0); chk("R9 off-address zero", rdata_o, 8'h00);
    step(A, 0, 0, 0, 0, 0, 0); chk("R9 off-address no clear", rdata_o, 8'h10);
    // R3 clearing read
    step(A, 1, 0, 0, 0, 0, 0);
    step(A, 0, 0, 0, 0, 0, 0); chk("R3 clear", rdata_o, 8'h00);
    // R4 pulse during clear
    step(A, 0, 0, 1, 0, 1, 0);
    step(A, 1, 0, 1, 0, 1, 0);
    step(A, 0, 0, 0, 0, 0, 0); chk("R4 set beats clear", rdata_o, 8'h18);
    // R5 live mirror
    step(A, 0, 0, 0, 1, 0, 0); chk("R5 txemp high", rdata_o, 8'h38);
    step(A, 0, 0, 0, 0, 0, 0); chk("R5 txemp low", rdata_o, 8'h18);
    // R7 select drops latched flag and masks pulses
    step(A, 0, 0, 0, 0, 0, 1); chk("R7 forced zero", rdata_o, 8'h10);
    step(A, 0, 0, 0, 0, 1, 1);
    step(A, 0, 0, 0, 0, 0, 0); chk("R7 stale flag dropped", rdata_o, 8'h10);
    // R6 sticky modem event
    step(A, 0, 0, 0, 0, 1, 0);
    step(A, 0, 0, 0, 0, 0, 0); chk("R6 ms set", rdata_o, 8'h18);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] e;
      step($urandom_range(7, 0), ($urandom_range(2, 0) == 0), ($urandom_range(5, 0) == 0),
           ($urandom_range(3, 0) == 0), $urandom_range(1, 0), ($urandom_range(3, 0) == 0),
           ($urandom_range(4, 0) == 0));
      e = exp_rd(addr_i, m_dma, m_ms, ms_sel_i, txemp_i);
      chk("R2 R3 dma bit", {3'b0, rdata_o[4], 4'b0}, {3'b0, e[4], 4'b0});
      chk("R6 R7 ms bit", {4'b0, rdata_o[3], 3'b0}, {4'b0, e[3], 3'b0});
      chk("R5 txe bit", {2'b0, rdata_o[5], 5'b0}, {2'b0, e[5], 5'b0});
      chk("R8 reserved", {rdata_o[7:6], 3'b0, rdata_o[2:0]}, 8'h00);
      if (addr_i != A) chk("R9 off-address", rdata_o, 8'h00);
    end
    look("R1 R4 final");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule